// File: doc/BRIEF.md
# Basic Timer with Watchdog and Wake-up Stabilization

This block is an 8-bit up-counter driven by a tick from a free-running prescaler. It does two jobs. In normal running it works as a watchdog: if software does not clear the counter before it wraps from all ones back to zero, the block raises a one-cycle system reset request. Writing one specific 4-bit key into the upper control field turns the watchdog off, and any other value turns it back on.

The same counter also times oscillator settling. After a power-on reset, or after a wake from Stop mode, the CPU clock enable stays low until counter bit 4 becomes 1. After a power-on reset the counter always runs at the slowest prescaler rate. After a wake caused by an external interrupt it runs at the rate software selected before entering Stop. Entering Stop drops the CPU clock enable and holds both the counter and the prescaler at zero, so every stabilization interval starts from a known point.

Software reaches the block through one 8-bit write port with a read-back. The field layout is: bits [7:4] hold the watchdog key, bits [3:2] select the rate, and bit 1 is the clear strobe.

Top module: `basic_timer_wdt`

## Requirements
- R1: While reset is asserted, `ctl_rdata` reads 8'h00, `wdt_rst_o` is 0 and `cpu_clk_en_o` is 0.
- R2: `ctl_rdata` returns the last written bits [7:2] in place, with bits [1:0] always reading 0. The clear strobe (bit 1) is not stored.
- R3: While the watchdog is enabled, a tick that arrives with the counter at 8'hFF wraps it to 0. On that same edge `wdt_rst_o` goes high for exactly one cycle.
- R4: While the key field bits [7:4] equal 4'b1010, counter wraps produce no reset request. Any other key value enables the watchdog, including the reset value 4'h0.
- R5: A write with bit 1 set zeroes the counter on that edge and wins over a coincident tick. A clear that lands on the edge where the counter would wrap therefore prevents the request, and regular clears keep `wdt_rst_o` low.
- R6: The rate field bits [3:2] give one tick every 2^PRE_W, 2^(PRE_W-2), 2^(PRE_W-5) or 2^(PRE_W-8) clock cycles for codes 00, 01, 10 and 11 (4096, 1024, 128 and 16 at the default PRE_W=12).
- R7: After reset release, `cpu_clk_en_o` rises on edge 16*2^PRE_W+1 counted from release. The counter runs at the code-00 rate in this phase regardless of any rate written meanwhile.
- R8: With `cpu_clk_en_o` high, `stop_i` high at an edge drops `cpu_clk_en_o` at that edge. The counter and prescaler are then held at zero until a wake occurs.
- R9: `ext_wake_i` high at an edge during Stop starts stabilization at the currently selected rate 2^k. `cpu_clk_en_o` rises on the (16*2^k+1)-th edge after the wake edge.
- R10: `ext_wake_i` has no effect outside Stop: `cpu_clk_en_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [7:4] key, [3:2] rate code, [1] clear |
| ctl_rdata | output | 8 | Control read-back: {key, rate code, 2'b00} |
| stop_i | input | 1 | Stop-mode request from the CPU |
| ext_wake_i | input | 1 | External interrupt wake request |
| wdt_rst_o | output | 1 | Registered one-cycle watchdog reset request |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |

## Verification
The bench builds the block with PRE_W=8, so the four rate codes give 256, 64, 8 and 1 cycles per tick. CNT_W and STAB_BIT keep their defaults. With code 11 the full 256-tick watchdog wrap takes 257 cycles, which allows an exact check of the pulse edge and of a clear landing on the wrap edge itself. The forced slowest rate after reset finishes in about 4100 cycles, and the four wake rates can each be timed to the exact edge, because Stop resets the prescaler phase.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2
  } bt_state_e;

  // Key value that turns the watchdog off
  localparam logic [3:0] WDT_OFF_KEY = 4'b1010;

  // Rate code -> log2 of cycles per tick; PRE_W must be at least 8
  function automatic int sel_shift(input logic [1:0] code, input int pre_w);
    case (code)
      2'b00:   return pre_w;
      2'b01:   return pre_w - 2;
      2'b10:   return pre_w - 5;
      default: return pre_w - 8;
    endcase
  endfunction

  // Tick mask: ones in the low 'sh' bits
  function automatic logic [31:0] low_mask(input int sh);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i < sh);
    return m;
  endfunction

endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int PRE_W = 12,
  localparam int SHW = $clog2(PRE_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_i,
  input  logic [SHW-1:0] shift_i,
  output logic           tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask   = PRE_W'(bt_pkg::low_mask(int'(shift_i)));
    tick_o = !hold_i && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (hold_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // Back-to-back ticks only at the divide-by-one setting
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && $past(tick_o) && $stable(shift_i) && !$past(hold_i)) |-> (shift_i == '0));

endmodule

// File: rtl/bt_ctrl_reg.sv
module bt_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [3:0] key_o,
  output logic [1:0] sel_o,
  output logic       clr_o,
  output logic       wdt_en_o,
  output logic [7:0] rdata_o
);

  logic [5:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (we_i) hold_q <= wdata_i[7:2];
  end

  always_comb begin
    key_o    = hold_q[5:2];
    sel_o    = hold_q[1:0];
    clr_o    = we_i && wdata_i[1];
    wdt_en_o = (key_o != bt_pkg::WDT_OFF_KEY);
    rdata_o  = {hold_q, 2'b00};
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we_i) |-> (rdata_o == {$past(wdata_i[7:2]), 2'b00}));

endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_o  = cnt_q;
    wrap_o = tick_i && !clr_i && !hold_i && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || hold_i) cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0));

endmodule

// File: rtl/bt_wake_fsm.sv
module bt_wake_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              ext_wake_i,
  input  logic              stab_done_i,
  output bt_pkg::bt_state_e state_o,
  output logic              por_phase_o,
  output logic              clk_en_o
);
  import bt_pkg::*;

  bt_state_e state_q, state_d;
  logic      por_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (stop_i)      state_d = ST_STOP;
      ST_STOP: if (ext_wake_i)  state_d = ST_STAB;
      ST_STAB: if (stab_done_i) state_d = ST_RUN;
      default:                  state_d = ST_STAB;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STAB;
      por_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_d == ST_RUN) por_q <= 1'b0;
    end
  end

  always_comb begin
    state_o     = state_q;
    por_phase_o = por_q;
    clk_en_o    = (state_q == ST_RUN);
  end

  assert_en_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> $past(stab_done_i));

  assert_en_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en_o) |-> $past(stop_i));

endmodule

// File: rtl/basic_timer_wdt.sv
module basic_timer_wdt #(
  parameter int PRE_W    = 12,
  parameter int CNT_W    = 8,
  parameter int STAB_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       stop_i,
  input  logic       ext_wake_i,
  output logic       wdt_rst_o,
  output logic       cpu_clk_en_o
);
  import bt_pkg::*;

  localparam int SHW = $clog2(PRE_W + 1);

  // Named internal events, visible to the assertions below
  logic [3:0]       key;
  logic [1:0]       sel;
  logic             clr_evt;
  logic             wdt_en;
  logic             tick_evt;
  logic             wrap_evt;
  logic             hold;
  logic             por_phase;
  logic [SHW-1:0]   shift;
  logic [CNT_W-1:0] cnt;
  bt_state_e        state;
  logic             wdt_q;

  bt_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (ctl_we),
    .wdata_i  (ctl_wdata),
    .key_o    (key),
    .sel_o    (sel),
    .clr_o    (clr_evt),
    .wdt_en_o (wdt_en),
    .rdata_o  (ctl_rdata)
  );

  // Slowest rate is forced while settling after power-on reset
  always_comb begin
    hold  = (state == ST_STOP);
    shift = por_phase ? SHW'(PRE_W) : SHW'(sel_shift(sel, PRE_W));
  end

  bt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold),
    .shift_i (shift),
    .tick_o  (tick_evt)
  );

  bt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_evt),
    .hold_i (hold),
    .tick_i (tick_evt),
    .cnt_o  (cnt),
    .wrap_o (wrap_evt)
  );

  bt_wake_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .ext_wake_i  (ext_wake_i),
    .stab_done_i (cnt[STAB_BIT]),
    .state_o     (state),
    .por_phase_o (por_phase),
    .clk_en_o    (cpu_clk_en_o)
  );

  // Registered request: glitch-free, one cycle per wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_q <= 1'b0;
    else        wdt_q <= wrap_evt && wdt_en;
  end

  assign wdt_rst_o = wdt_q;

  assert_wdt_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  assert_wdt_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> ((cnt == '0) && ($past(cnt) == {CNT_W{1'b1}})));

  assert_key_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> ($past(key) != WDT_OFF_KEY));

  assert_wake_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && !stop_i) |=> cpu_clk_en_o);

endmodule

// File: tb/tb_basic_timer_wdt.sv
`timescale 1ns/1ps
module tb_basic_timer_wdt;

  localparam int PW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       stop_i = 1'b0;
  logic       ext_wake_i = 1'b0;
  logic       wdt_rst_o;
  logic       cpu_clk_en_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  basic_timer_wdt #(.PRE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .stop_i(stop_i), .ext_wake_i(ext_wake_i),
    .wdt_rst_o(wdt_rst_o), .cpu_clk_en_o(cpu_clk_en_o)
  );

  // Cycles per tick for each rate code at PW=8
  function automatic int ratio(input logic [1:0] code);
    case (code)
      2'b00: return 256;
      2'b01: return 64;
      2'b10: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; leaves at the negedge after the sampling edge
  task automatic wr(input logic [7:0] d);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_en(input int start, input int limit, output int n);
    bit seen = 0;
    n = start;
    while (n < limit && !seen) begin
      @(posedge clk); n++;
      @(negedge clk); if (cpu_clk_en_o) seen = 1;
    end
    if (!seen) n = -1;
  endtask

  task automatic wait_wdt(input int start, input int limit, output int n);
    bit seen = 0;
    n = start;
    while (n < limit && !seen) begin
      @(posedge clk); n++;
      @(negedge clk); if (wdt_rst_o) seen = 1;
    end
    if (!seen) n = -1;
  endtask

  task automatic quiet_wdt(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); if (wdt_rst_o) hits++;
    end
  endtask

  task automatic t_reset_and_por(input bit write_fast);
    int n;
    int exp;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ctl_rdata == 8'h00, "R1", "rdata in reset", ctl_rdata, 0);
    check(wdt_rst_o == 1'b0, "R1", "wdt in reset", wdt_rst_o, 0);
    check(cpu_clk_en_o == 1'b0, "R1", "clk_en in reset", cpu_clk_en_o, 0);
    rst_n = 1'b1;
    exp = 16 * ratio(2'b00) + 1;
    if (write_fast) begin
      wr(8'h0C);
      check(ctl_rdata == 8'h0C, "R2", "rate readback during settle", ctl_rdata, 8'h0C);
      wait_en(1, 6000, n);
      check(n == exp, "R7", "settle edge with fast rate written", n, exp);
    end else begin
      wait_en(0, 6000, n);
      check(n == exp, "R7", "settle edge after reset", n, exp);
    end
  endtask

  task automatic t_readback;
    wr(8'hFF);
    check(ctl_rdata == 8'hFC, "R2", "readback of FF", ctl_rdata, 8'hFC);
    wr(8'h53);
    check(ctl_rdata == 8'h50, "R2", "readback of 53", ctl_rdata, 8'h50);
  endtask

  task automatic t_wdt_fire;
    int n;
    wr(8'h0E);
    wait_wdt(1, 400, n);
    check(n == 257, "R3", "wrap request edge", n, 257);
    @(negedge clk);
    check(wdt_rst_o == 1'b0, "R3", "request width one cycle", wdt_rst_o, 0);
  endtask

  task automatic t_last_clear;
    int n;
    int hits = 0;
    wr(8'h0E);
    n = 1;
    while (n < 256) begin
      @(posedge clk); n++;
      @(negedge clk); if (wdt_rst_o) hits++;
    end
    wr(8'h0E);
    check(hits == 0 && wdt_rst_o == 1'b0, "R5", "clear on wrap edge", hits + wdt_rst_o, 0);
    wait_wdt(1, 400, n);
    check(n == 257, "R5", "count restarts after clear", n, 257);
  endtask

  task automatic t_periodic_clear;
    int hits;
    int total = 0;
    for (int i = 0; i < 5; i++) begin
      wr(8'h0E);
      quiet_wdt(199, hits);
      total += hits;
    end
    check(total == 0, "R5", "periodic clears", total, 0);
  endtask

  task automatic t_key_off;
    int hits;
    wr(8'hAE);
    quiet_wdt(700, hits);
    check(hits == 0, "R4", "key 1010 disables", hits, 0);
  endtask

  task automatic t_wake_ignored;
    int lows = 0;
    ext_wake_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_wake_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!cpu_clk_en_o) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R10", "wake outside stop", lows, 0);
  endtask

  task automatic t_stop_wake(input logic [1:0] code);
    int n;
    int exp;
    int highs = 0;
    wr({4'b1010, code, 2'b10});
    stop_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop_i = 1'b0;
    check(cpu_clk_en_o == 1'b0, "R8", "clk_en drops on stop", cpu_clk_en_o, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (cpu_clk_en_o) highs++;
    end
    check(highs == 0, "R8", "clk_en held low in stop", highs, 0);
    ext_wake_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_wake_i = 1'b0;
    exp = 16 * ratio(code) + 2;
    wait_en(1, 6000, n);
    check(n == exp, "R9", $sformatf("R6 wake settle edge code %0d", code), n, exp);
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_por(1'b0);
    t_readback();
    t_wdt_fire();
    t_last_clear();
    t_periodic_clear();
    t_key_off();
    t_wake_ignored();
    t_stop_wake(2'b11);
    t_stop_wake(2'b10);
    t_stop_wake(2'b01);
    t_stop_wake(2'b00);
    t_reset_and_por(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL timeout: actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule